// File: doc/BRIEF.md
# PCI interrupt aggregator and router

This block collects the four active-low PCI INTx pins, four bus-error event
pulses and two DMA event pulses, and presents them to a system interrupt
controller on up to five level-sensitive request lines. A two-bit build-time
parameter picks how the sources are spread over those lines. The spread runs
from one line shared by everything to one line per INTx pin with a separate
DMA line. Whenever the lines are split, error requests travel on the INTA line.

Software reaches two 32-bit registers over a plain single-cycle register bus.
The control register holds a per-pin enable mask and two error-group enables.
The status register has three parts: the synchronised INTx pin levels, sticky
event flags that are cleared by writing one to them, and the build-time mode
as a read-only field. An interrupt handler reads status to learn which source
is pending. It clears the event flags it has serviced. INTx lines drop by
themselves once the device releases its pin.

Top module: `pci_irq_router`

## Requirements
- R1: After reset the control register reads 0, all event flags are 0 and every bit of `irq_out` is 0.
- R2: Byte address 0x0 is the control register: bits 3:0 enable INTA..INTD (bit 0 = INTA), bit 25 enables the parity, target-abort and master-abort error requests, bit 27 enables the system-error request. All other control bits read 0. Address 0x4 is the status register. Read data is valid in the same cycle as `bus_en` with `bus_we` low.
- R3: Status bits 11:8 show the synchronised INTx pin levels, bit 8 = INTA up to bit 11 = INTD, active low (0 = asserted). This holds whether or not the pin is enabled. A pin change appears there two clock edges after it is sampled.
- R4: A one-cycle pulse sets a sticky flag: `err_evt[0]` sets status bit 12 (parity), `err_evt[1]` bit 13 (target abort), `err_evt[2]` bit 14 (master abort), `err_evt[3]` bit 17 (system error), `dma_evt[1]` bit 15 (DMA error), `dma_evt[0]` bit 16 (DMA done).
- R5: Writing 1 to a flag bit of the status register clears it, and writing 0 leaves it unchanged. If a pulse arrives in the same cycle as the clearing write, the flag stays set.
- R6: Status bits 25:24 read the MODE parameter, and writes do not change them.
- R7: An INTx request is an asserted pin whose enable bit is 1. The error request is (bit 25 and any of flags 12, 13, 14) or (bit 27 and flag 17). The DMA request is flag 15 or flag 16, with no enable.
- R8: MODE 0: `irq_out[0]` is the OR of all INTx, error and DMA requests, and `irq_out[4:1]` stay 0.
- R9: MODE 1: `irq_out[0]` carries all INTx and error requests, `irq_out[4]` carries the DMA request, and `irq_out[3:1]` stay 0.
- R10: MODE 2: `irq_out[i]` carries the INTx request of pin i (0 = INTA). The error and DMA requests are also ORed onto `irq_out[0]`, and `irq_out[4]` stays 0.
- R11: MODE 3: like MODE 2, except that the DMA request drives `irq_out[4]` alone.
- R12: Output lines are registered and level-sensitive. A line rises one clock after its request appears, stays high while the request persists, and falls one clock after the request ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| intx_n | input | 4 | Asynchronous INTx pins, active low, bit 0 = INTA |
| err_evt | input | 4 | Error event pulses: parity, target abort, master abort, system error |
| dma_evt | input | 2 | DMA event pulses: bit 0 done, bit 1 error |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_out | output | 5 | System interrupt request lines |

## Verification
The hardest situation to reach from the ports is a clearing write and a new event pulse landing on the same flag in the same cycle. The stimulus lines the pulse and the write up on one falling edge, so both are sampled on the same rising edge, and then reads the flag back. The two-edge synchroniser latency is also awkward to observe. It is checked by reading status and the mode-3 line edge by edge after a single pin change. All four routing modes are built side by side and driven with identical stimulus, so every vector checks every mapping.

// File: rtl/pci_irq_pkg.sv
// Shared constants for the PCI interrupt router: register offsets, field
// positions and source counts. Assumes a 32-bit register data path.
package pci_irq_pkg;
    localparam int unsigned NUM_INTX   = 4;
    localparam int unsigned NUM_FLAGS  = 6;
    localparam int unsigned NUM_LINES  = 5;
    localparam int unsigned REG_W      = 32;

    localparam int unsigned OFS_CTRL   = 0;
    localparam int unsigned OFS_STAT   = 4;

    // Control fields
    localparam int unsigned CB_ERR_EN  = 25;
    localparam int unsigned CB_SYS_EN  = 27;

    // Status fields
    localparam int unsigned SB_PIN_LO  = 8;
    localparam int unsigned SB_FLAG_LO = 12;
    localparam int unsigned SB_MODE_LO = 24;

    // Flag index = status bit - SB_FLAG_LO
    localparam int unsigned FI_PAR     = 0;
    localparam int unsigned FI_TABT    = 1;
    localparam int unsigned FI_MABT    = 2;
    localparam int unsigned FI_DMAERR  = 3;
    localparam int unsigned FI_DMADONE = 4;
    localparam int unsigned FI_SYS     = 5;
endpackage

// File: rtl/pci_irq_sync.sv
// Multi-flop synchroniser for the asynchronous INTx pins.
// Assumes the pins are active low, so the flops reset to the released level.
module pci_irq_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_n,
    output logic [WIDTH-1:0] lvl_n
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // One synchroniser stage, first stage fed by the pins.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= '1;
                else if (s == 0)
                    stage_q[s] <= pin_n;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign lvl_n = stage_q[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            // R3: a synchronised level change matches the pins two edges earlier
            a_r3_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(lvl_n) |-> (lvl_n == $past(pin_n, 2)));
        end
    endgenerate
endmodule

// File: rtl/pci_irq_regs.sv
// Control and status registers. Control stores the enable mask and the error
// group enables. Status holds the sticky write-one-to-clear event flags, and
// its read view adds the pin levels and the build-time mode.
// Assumes single-cycle bus accesses and single-cycle event pulses.
module pci_irq_regs
    import pci_irq_pkg::*;
#(
    parameter int unsigned MODE   = 0,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [NUM_INTX-1:0]  pin_lvl_n,
    input  logic [NUM_FLAGS-1:0] evt_set,
    output logic [NUM_INTX-1:0]  ctrl_mask,
    output logic                 ctrl_err_en,
    output logic                 ctrl_sys_en,
    output logic [NUM_FLAGS-1:0] flags
);
    localparam logic [1:0] MODE_BITS = 2'(MODE);

    logic                 wr_ctrl, wr_stat;
    logic [NUM_FLAGS-1:0] clr_mask;
    logic [REG_W-1:0]     ctrl_view, stat_view;

    // Decode register writes.
    always_comb begin
        wr_ctrl  = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
        wr_stat  = bus_en && bus_we && (bus_addr == ADDR_W'(OFS_STAT));
        clr_mask = wr_stat ? bus_wdata[SB_FLAG_LO +: NUM_FLAGS] : '0;
    end

    // Control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_mask   <= '0;
            ctrl_err_en <= 1'b0;
            ctrl_sys_en <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_mask   <= bus_wdata[NUM_INTX-1:0];
            ctrl_err_en <= bus_wdata[CB_ERR_EN];
            ctrl_sys_en <= bus_wdata[CB_SYS_EN];
        end
    end

    // Sticky event flags; a new pulse wins over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (flags & ~clr_mask) | evt_set;
    end

    // Assemble the read views of both registers.
    always_comb begin
        ctrl_view = '0;
        ctrl_view[NUM_INTX-1:0] = ctrl_mask;
        ctrl_view[CB_ERR_EN]    = ctrl_err_en;
        ctrl_view[CB_SYS_EN]    = ctrl_sys_en;
        stat_view = '0;
        stat_view[SB_PIN_LO +: NUM_INTX]   = pin_lvl_n;
        stat_view[SB_FLAG_LO +: NUM_FLAGS] = flags;
        stat_view[SB_MODE_LO +: 2]         = MODE_BITS;
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            if (bus_addr == ADDR_W'(OFS_CTRL))
                bus_rdata = ctrl_view;
            else if (bus_addr == ADDR_W'(OFS_STAT))
                bus_rdata = stat_view;
        end
    end

    generate
        for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag_chk
            // R4: an event pulse always leaves its flag set
            a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
                evt_set[f] |=> flags[f]);
            // R5: a flag with no clearing write stays set
            a_r5_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (flags[f] && !(bus_en && bus_we && bus_addr == ADDR_W'(OFS_STAT)
                               && bus_wdata[SB_FLAG_LO+f])) |=> flags[f]);
        end
    endgenerate
endmodule

// File: rtl/pci_irq_route.sv
// Spreads the INTx, error and DMA requests over the output lines according to
// the build-time mode and registers the result. Unused lines are held low.
module pci_irq_route
    import pci_irq_pkg::*;
#(
    parameter int unsigned MODE = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_INTX-1:0]  intx_req,
    input  logic                 err_req,
    input  logic                 dma_req,
    output logic [NUM_LINES-1:0] irq_q
);
    logic [NUM_LINES-1:0] irq_d;
    logic                 any_intx;

    assign any_intx = |intx_req;

    generate
        if (MODE == 0) begin : g_shared
            assign irq_d = {4'b0, any_intx | err_req | dma_req};
        end else if (MODE == 1) begin : g_dma_apart
            assign irq_d = {dma_req, 3'b0, any_intx | err_req};
        end else if (MODE == 2) begin : g_split
            assign irq_d = {1'b0, intx_req[3:1], intx_req[0] | err_req | dma_req};
        end else begin : g_split_dma
            assign irq_d = {dma_req, intx_req[3:1], intx_req[0] | err_req};
        end
    endgenerate

    // Register the output lines.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= '0;
        else
            irq_q <= irq_d;
    end
endmodule

// File: rtl/pci_irq_router.sv
// Top of the PCI interrupt router: synchronises the INTx pins, holds the
// control/status registers, forms the per-source requests and routes them
// onto up to five level-sensitive lines. MODE is fixed at build time (0..3).
module pci_irq_router
    import pci_irq_pkg::*;
#(
    parameter int unsigned MODE        = 0,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           intx_n,
    input  logic [3:0]           err_evt,
    input  logic [1:0]           dma_evt,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [4:0]           irq_out
);
    logic [NUM_INTX-1:0]  pin_lvl_n;
    logic [NUM_INTX-1:0]  ctrl_mask;
    logic                 ctrl_err_en, ctrl_sys_en;
    logic [NUM_FLAGS-1:0] flags, evt_set;
    logic [NUM_INTX-1:0]  intx_req;
    logic                 err_req, dma_req;

    pci_irq_sync #(.WIDTH(NUM_INTX), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (intx_n),
        .lvl_n (pin_lvl_n)
    );

    // Place the event pulses at their flag positions.
    always_comb begin
        evt_set             = '0;
        evt_set[FI_PAR]     = err_evt[0];
        evt_set[FI_TABT]    = err_evt[1];
        evt_set[FI_MABT]    = err_evt[2];
        evt_set[FI_SYS]     = err_evt[3];
        evt_set[FI_DMAERR]  = dma_evt[1];
        evt_set[FI_DMADONE] = dma_evt[0];
    end

    pci_irq_regs #(.MODE(MODE), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_en      (bus_en),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .pin_lvl_n   (pin_lvl_n),
        .evt_set     (evt_set),
        .ctrl_mask   (ctrl_mask),
        .ctrl_err_en (ctrl_err_en),
        .ctrl_sys_en (ctrl_sys_en),
        .flags       (flags)
    );

    // Form the per-source requests from levels, flags and enables.
    always_comb begin
        intx_req = ~pin_lvl_n & ctrl_mask;
        err_req  = (ctrl_err_en & (flags[FI_PAR] | flags[FI_TABT] | flags[FI_MABT]))
                 | (ctrl_sys_en & flags[FI_SYS]);
        dma_req  = flags[FI_DMAERR] | flags[FI_DMADONE];
    end

    pci_irq_route #(.MODE(MODE)) u_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .intx_req (intx_req),
        .err_req  (err_req),
        .dma_req  (dma_req),
        .irq_q    (irq_out)
    );

    // R12: with nothing pending and no pin enabled, every line is low next cycle
    a_r12_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags == '0) && ((ctrl_mask & ~pin_lvl_n) == '0)) |=> (irq_out == '0));

    // R7: an unmasked asserted pin always raises some line next cycle
    a_r7_intx_raises: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_mask & ~pin_lvl_n) != '0) |=> (irq_out != '0));

    generate
        if (MODE == 3) begin : g_chk_m3
            // R11: a pending DMA flag drives the separate DMA line
            a_r11_dma_line: assert property (@(posedge clk) disable iff (!rst_n)
                (flags[FI_DMAERR] || flags[FI_DMADONE]) |=> irq_out[4]);
        end
    endgenerate
endmodule

// File: tb/test_pci_irq_router.sv
`timescale 1ns/1ps
module test_pci_irq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  intx_n = 4'hF;
    logic [3:0]  err_evt = '0;
    logic [1:0]  dma_evt = '0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_w [4];
    logic [4:0]  irq_w   [4];

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    generate
        for (genvar m = 0; m < 4; m++) begin : g_mode
            pci_irq_router #(.MODE(m), .ADDR_W(8), .SYNC_STAGES(2)) i_pci_irq_router (
                .clk(clk), .rst_n(rst_n), .intx_n(intx_n), .err_evt(err_evt),
                .dma_evt(dma_evt), .bus_en(bus_en), .bus_we(bus_we),
                .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                .bus_rdata(rdata_w[m]), .irq_out(irq_w[m]));
        end
    endgenerate

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(int m, logic [7:0] a, output logic [31:0] d);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #0.5;
        d = rdata_w[m];
        bus_en = 0;
    endtask

    task automatic pulse(logic [3:0] e, logic [1:0] dm);
        err_evt = e; dma_evt = dm;
        @(negedge clk);
        err_evt = '0; dma_evt = '0;
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [4:0] exp_irq(int m, logic [3:0] pn, logic [3:0] e,
                                           logic [1:0] dm, logic [3:0] mk,
                                           logic ei, logic si);
        logic [3:0] ix;
        logic er, dr;
        ix = ~pn & mk;
        er = (ei & |e[2:0]) | (si & e[3]);
        dr = |dm;
        case (m)
            0: return {4'b0, |ix | er | dr};
            1: return {dr, 3'b0, |ix | er};
            2: return {1'b0, ix[3:1], ix[0] | er | dr};
            default: return {dr, ix[3:1], ix[0] | er};
        endcase
    endfunction

    // {pins_n[15:12], err[11:8], dma[7:6], mask[5:2], err_en[1], sys_en[0]}
    localparam logic [15:0] VEC [9] = '{
        16'b1110_0000_00_1111_0_0,
        16'b0111_0000_00_0111_0_0,
        16'b1111_0001_00_0000_1_0,
        16'b1111_1000_00_0000_1_0,
        16'b1111_1000_00_0000_0_1,
        16'b1111_0000_01_0000_0_0,
        16'b1101_0000_10_0010_0_0,
        16'b0000_0100_00_1010_0_0,
        16'b1011_0010_11_1111_1_0
    };

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        cycles(4);
        rst_n = 1;
        cycles(2);

        // R1 and R6: reset state of every mode instance
        for (int m = 0; m < 4; m++) begin
            check("R1 irq after reset", {27'b0, irq_w[m]}, 32'h0);
            rd(m, 8'h0, d); check("R1 ctrl after reset", d, 32'h0);
            rd(m, 8'h4, d); check("R6 status after reset", d, (32'(m) << 24) | 32'h0F00);
        end

        // R6: mode field is read-only; R2: only implemented control bits stick
        wr(8'h4, 32'h0300_0000);
        wr(8'h0, 32'hFFFF_FFFF);
        for (int m = 0; m < 4; m++) begin
            rd(m, 8'h4, d); check("R6 mode read-only", d[25:24], 32'(m));
            rd(m, 8'h0, d); check("R2 ctrl read-back", d, 32'h0A00_000F);
        end

        // R3 and R12: pin latency, edge by edge (mode 3 instance)
        intx_n = 4'b1110;
        @(negedge clk);
        rd(3, 8'h4, d); check("R3 pins after 1 edge", d[11:8], 32'hF);
        @(negedge clk);
        rd(3, 8'h4, d); check("R3 pins after 2 edges", d[11:8], 32'hE);
        check("R12 irq not yet after 2 edges", {27'b0, irq_w[3]}, 32'h0);
        @(negedge clk);
        check("R12 irq after 3 edges", {27'b0, irq_w[3]}, 32'h1);
        // R3: masked pin still visible in status
        wr(8'h0, 32'h0);
        intx_n = 4'b0111;
        cycles(4);
        rd(2, 8'h4, d); check("R3 masked pin visible", d[11:8], 32'h7);
        check("R7 masked pin no irq", {27'b0, irq_w[2]}, 32'h0);
        intx_n = 4'hF;
        cycles(4);

        // R5: zero write keeps flag, partial clear, set wins over clear
        pulse(4'b0011, 2'b00);
        wr(8'h4, 32'h0);
        rd(0, 8'h4, d); check("R5 zero write keeps flags", d[17:12], 32'h03);
        wr(8'h4, 32'h0000_1000);
        rd(0, 8'h4, d); check("R5 partial clear", d[17:12], 32'h02);
        err_evt = 4'b0001;
        wr(8'h4, 32'h0000_1000);
        err_evt = '0;
        rd(0, 8'h4, d); check("R5 pulse wins over clear", d[17:12], 32'h03);

        // R12: line falls one clock after the request is cleared
        wr(8'h0, 32'h0200_0000);
        cycles(2);
        check("R12 error line high", {27'b0, irq_w[0]}, 32'h1);
        wr(8'h4, 32'hFFFF_FFFF);
        check("R12 still high one edge after clear", {27'b0, irq_w[0]}, 32'h1);
        @(negedge clk);
        check("R12 low two edges after clear", {27'b0, irq_w[0]}, 32'h0);

        // R4, R7..R11: vector table over all modes
        for (int v = 0; v < 9; v++) begin
            logic [15:0] t;
            t = VEC[v];
            wr(8'h0, {4'b0, t[0], 1'b0, t[1], 21'b0, t[5:2]});
            intx_n = t[15:12];
            pulse(t[11:8], t[7:6]);
            cycles(4);
            for (int m = 0; m < 4; m++) begin
                string r;
                r = (m == 0) ? "R8" : (m == 1) ? "R9" : (m == 2) ? "R10" : "R11";
                check($sformatf("%s R7 vector %0d", r, v), {27'b0, irq_w[m]},
                      {27'b0, exp_irq(m, t[15:12], t[11:8], t[7:6], t[5:2], t[1], t[0])});
            end
            rd(1, 8'h4, d);
            check($sformatf("R4 flags vector %0d", v), d[17:12],
                  {26'b0, t[11], t[6], t[7], t[10], t[9], t[8]});
            wr(8'h4, 32'hFFFF_FFFF);
            intx_n = 4'hF;
            cycles(4);
            check($sformatf("R12 cleared vector %0d", v), {27'b0, irq_w[3]}, 32'h0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule